// File: doc/BRIEF.md
# DMA Bus Address Relocation Map

This block sits between an 18-bit DMA bus and a 22-bit physical memory. For each bus request it produces a physical address. The bus address is split into a 5-bit page number, bits [17:13], and a 13-bit in-page offset. When relocation is on and the page falls inside a programmed window, the page number selects one of 32 relocation registers. That register's base, which is always word aligned, is added to the word offset. This lets a DMA master with a small address range reach any word-aligned 4K-word region of physical memory.

Two windows decide which pages are relocated. A lower window grows upward from page 0, and an upper window grows downward from the I/O page. A force input replaces both programmed limits with defaults that cover all non-I/O pages. The top page is the I/O page. It always lands on the top 4K words of physical space, whatever the enable or register contents. Register 31 can therefore be read and written but is never used for translation. Each relocated address is also kept in a last-mapped-address register for inspection.

The translation is registered. A request presented on one clock edge produces its result, with a valid strobe, in the following cycle. A two-state control machine tracks this: `ST_IDLE` means no result is being presented, and `ST_EMIT` means a result is on the outputs. It moves IDLE→EMIT on a request (transition "accept"). It stays in EMIT on back-to-back requests ("stream"). It returns EMIT→IDLE when there is no request ("drain"). It stays in IDLE otherwise ("wait").

Top module: `bus_reloc_map`

## Requirements
- R1: When an address is relocated, phys_addr[21:1] equals the selected register's stored bits [21:1] plus bus_addr[12:1], zero-extended to 21 bits and taken modulo 2^21. The register index is bus_addr[17:13].
- R2: phys_addr[0] always equals bus_addr[0] of the same request.
- R3: A write with wr_en stores wr_data (21 bits, meaning bits [21:1]) into register wr_idx at the clock edge. rd_data reads register rd_idx combinationally as {stored[21:1], 1'b0}, so bit 0 is always zero.
- R4: A request whose page is 31 (bus address 760000 octal and above) yields phys_addr = {9'h1FF, bus_addr[12:0]} with reloc_hit = 0. This holds regardless of map_en and of register 31.
- R5: With map_en = 0, every non-I/O request yields phys_addr = {4'b0, bus_addr} with reloc_hit = 0.
- R6: With map_en = 1, a non-I/O page p is relocated (reloc_hit = 1) exactly when p < lower limit or p >= upper limit. Limits are in 4K-word pages. A lower limit of 0 gives no lower window, an upper limit of 31 gives no upper window, and overlapping limits relocate every non-I/O page.
- R7: With map_en = 1, a non-I/O page outside both windows yields phys_addr = {4'b0, bus_addr} with reloc_hit = 0.
- R8: With force_dflt = 1, the limit inputs are ignored and lower = 0, upper = 0 are used, so every non-I/O page is relocated.
- R9: lma resets to 0. It takes the value of phys_addr on each result with reloc_hit = 1, and holds otherwise.
- R10: out_valid is high in the cycle after a clock edge that sampled req_valid = 1, and low otherwise. When out_valid is low, phys_addr and reloc_hit hold their last values. All outputs are 0 after reset.
- R11: A translation and a register write sampled on the same edge translate using the register content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| bus_addr | input | 18 | Bus byte address to translate |
| map_en | input | 1 | Global relocation enable |
| force_dflt | input | 1 | Use default window limits |
| lo_lim | input | 5 | Lower limit, first page not in lower window |
| up_lim | input | 5 | Upper limit, first page of upper window |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register to write |
| wr_data | input | 21 | Base bits [21:1] to store |
| rd_idx | input | 5 | Register to read |
| rd_data | output | 22 | Selected register, bit 0 zero |
| out_valid | output | 1 | Result strobe |
| phys_addr | output | 22 | Translated physical address |
| reloc_hit | output | 1 | Result was relocated through a register |
| lma | output | 22 | Last relocated physical address |

## Verification
The bench builds the block with its default parameters: an 18-bit bus, a 22-bit physical space and 13 offset bits, giving 32 registers and 5-bit limits. With these values every page number, every limit pair including the empty and overlapping cases, the I/O page and the 21-bit adder wrap can be reached. A few hundred random requests therefore cover the whole window decision table. Directed cases pin the adder carry out of bit 21, the same-edge write against translation, and the force input overriding hostile limits.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } reloc_state_t;
endpackage

// File: rtl/reloc_regfile.sv
module reloc_regfile #(
    parameter int IDXW = 5,
    parameter int BASEW = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [BASEW-1:0] wr_data,
    input  logic [IDXW-1:0]  sel_idx,
    output logic [BASEW-1:0] sel_base,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [BASEW-1:0] rd_base
);
    localparam int NREG = 1 << IDXW;

    logic [BASEW-1:0] bank [NREG];

    // One storage word per relocation register
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_idx == IDXW'(g))) begin
                bank[g] <= wr_data;
            end
        end
    end

    assign sel_base = bank[sel_idx];
    assign rd_base  = bank[rd_idx];
endmodule

// File: rtl/reloc_window.sv
module reloc_window #(
    parameter int IDXW = 5
) (
    input  logic [IDXW-1:0] page,
    input  logic            map_en,
    input  logic            force_dflt,
    input  logic [IDXW-1:0] lo_lim,
    input  logic [IDXW-1:0] up_lim,
    output logic            io_page,
    output logic            do_reloc
);
    localparam logic [IDXW-1:0] IO_PAGE = '1;
    localparam logic [IDXW-1:0] DFLT_LO = '0;
    localparam logic [IDXW-1:0] DFLT_UP = '0;

    logic [IDXW-1:0] lo_eff;
    logic [IDXW-1:0] up_eff;
    logic            in_lower;
    logic            in_upper;

    always_comb begin
        lo_eff   = force_dflt ? DFLT_LO : lo_lim;
        up_eff   = force_dflt ? DFLT_UP : up_lim;
        io_page  = (page == IO_PAGE);
        in_lower = (page < lo_eff);
        in_upper = (page >= up_eff);
        do_reloc = map_en && !io_page && (in_lower || in_upper);
    end
endmodule

// File: rtl/reloc_adder.sv
module reloc_adder #(
    parameter int BASEW = 21,
    parameter int OFFW  = 12
) (
    input  logic [BASEW-1:0] base,
    input  logic [OFFW-1:0]  word_off,
    output logic [BASEW-1:0] sum
);
    localparam int PADW = BASEW - OFFW;

    assign sum = base + {{PADW{1'b0}}, word_off};
endmodule

// File: rtl/bus_reloc_map.sv
module bus_reloc_map #(
    parameter int BUS_AW  = 18,
    parameter int PHYS_AW = 22,
    parameter int OFF_AW  = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [BUS_AW-1:0]          bus_addr,
    input  logic                       map_en,
    input  logic                       force_dflt,
    input  logic [BUS_AW-OFF_AW-1:0]   lo_lim,
    input  logic [BUS_AW-OFF_AW-1:0]   up_lim,
    input  logic                       wr_en,
    input  logic [BUS_AW-OFF_AW-1:0]   wr_idx,
    input  logic [PHYS_AW-2:0]         wr_data,
    input  logic [BUS_AW-OFF_AW-1:0]   rd_idx,
    output logic [PHYS_AW-1:0]         rd_data,
    output logic                       out_valid,
    output logic [PHYS_AW-1:0]         phys_addr,
    output logic                       reloc_hit,
    output logic [PHYS_AW-1:0]         lma
);
    import reloc_pkg::*;

    localparam int IDXW  = BUS_AW - OFF_AW;
    localparam int BASEW = PHYS_AW - 1;
    localparam int WOFFW = OFF_AW - 1;
    localparam int TOPW  = PHYS_AW - OFF_AW;
    localparam int EXTW  = PHYS_AW - BUS_AW;

    reloc_state_t     state_q;
    reloc_state_t     state_d;

    logic [IDXW-1:0]    page;
    logic [BASEW-1:0]   sel_base;
    logic [BASEW-1:0]   rd_base;
    logic [BASEW-1:0]   sum;
    logic               io_page;
    logic               do_reloc;
    logic [PHYS_AW-1:0] xlat_d;

    assign page = bus_addr[BUS_AW-1:OFF_AW];

    reloc_regfile #(.IDXW(IDXW), .BASEW(BASEW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sel_idx  (page),
        .sel_base (sel_base),
        .rd_idx   (rd_idx),
        .rd_base  (rd_base)
    );

    reloc_window #(.IDXW(IDXW)) u_win (
        .page       (page),
        .map_en     (map_en),
        .force_dflt (force_dflt),
        .lo_lim     (lo_lim),
        .up_lim     (up_lim),
        .io_page    (io_page),
        .do_reloc   (do_reloc)
    );

    reloc_adder #(.BASEW(BASEW), .OFFW(WOFFW)) u_add (
        .base     (sel_base),
        .word_off (bus_addr[OFF_AW-1:1]),
        .sum      (sum)
    );

    assign rd_data = {rd_base, 1'b0};

    // Address selection: I/O page, relocated, or pass-through
    always_comb begin
        if (io_page) begin
            xlat_d = {{TOPW{1'b1}}, bus_addr[OFF_AW-1:0]};
        end else if (do_reloc) begin
            xlat_d = {sum, bus_addr[0]};
        end else begin
            xlat_d = {{EXTW{1'b0}}, bus_addr};
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;  // accept / wait
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;  // stream / drain
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_addr <= '0;
            reloc_hit <= 1'b0;
            lma       <= '0;
        end else if (req_valid) begin
            phys_addr <= xlat_d;
            reloc_hit <= do_reloc;
            if (do_reloc) begin
                lma <= xlat_d;
            end
        end
    end

    // Output decode from state
    always_comb begin
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/reloc_map_checker.sv
module reloc_map_checker #(
    parameter int BUS_AW  = 18,
    parameter int PHYS_AW = 22,
    parameter int OFF_AW  = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic               map_en,
    input logic [PHYS_AW-1:0] rd_data,
    input logic               out_valid,
    input logic [PHYS_AW-1:0] phys_addr,
    input logic               reloc_hit,
    input logic [PHYS_AW-1:0] lma
);
    localparam int TOPW = PHYS_AW - OFF_AW;
    localparam int EXTW = PHYS_AW - BUS_AW;

    // R10: strobe follows the request by one cycle
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R2: byte bit passes straight through
    a_r2_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (phys_addr[0] == $past(bus_addr[0])));

    // R4: I/O page always lands at the top of physical space
    a_r4_io_page: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (&bus_addr[BUS_AW-1:OFF_AW])) |=>
        ((&phys_addr[PHYS_AW-1:OFF_AW]) && !reloc_hit));

    // R5: disabled map is transparent
    a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !map_en && !(&bus_addr[BUS_AW-1:OFF_AW])) |=>
        (!reloc_hit && phys_addr == {{EXTW{1'b0}}, $past(bus_addr)}));

    // R9: last-mapped register tracks relocated results
    a_r9_lma_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && reloc_hit) |-> (lma == phys_addr));

    // R3: low bit of every register reads zero
    a_r3_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

    // R10: held outputs while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(phys_addr) && $stable(reloc_hit));

    localparam logic [TOPW-1:0] TOP_ONES = '1;
endmodule

bind bus_reloc_map reloc_map_checker #(
    .BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .OFF_AW(OFF_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bus_addr  (bus_addr),
    .map_en    (map_en),
    .rd_data   (rd_data),
    .out_valid (out_valid),
    .phys_addr (phys_addr),
    .reloc_hit (reloc_hit),
    .lma       (lma)
);

// File: tb/bus_reloc_map_bench.sv
`timescale 1ns/1ps
module bus_reloc_map_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] bus_addr = '0;
    logic        map_en = 1'b0;
    logic        force_dflt = 1'b0;
    logic [4:0]  lo_lim = '0;
    logic [4:0]  up_lim = 5'd31;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [20:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [21:0] rd_data;
    logic        out_valid;
    logic [21:0] phys_addr;
    logic        reloc_hit;
    logic [21:0] lma;

    int n_cmp = 0;
    int n_bad = 0;
    logic [20:0] mdl [32];
    logic [21:0] exp_lma = '0;
    logic [21:0] exp_phys = '0;
    logic        exp_hit = 1'b0;

    always #2 clk = ~clk;

    bus_reloc_map u_bus_reloc_map (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_addr(bus_addr),
        .map_en(map_en), .force_dflt(force_dflt), .lo_lim(lo_lim), .up_lim(up_lim),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .out_valid(out_valid), .phys_addr(phys_addr),
        .reloc_hit(reloc_hit), .lma(lma)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Expected translation: {hit, phys}
    function automatic logic [22:0] model(input logic [17:0] a, input logic en,
                                          input logic frc, input logic [4:0] lo,
                                          input logic [4:0] up);
        logic [4:0]  pg = a[17:13];
        logic [4:0]  l = frc ? 5'd0 : lo;
        logic [4:0]  u = frc ? 5'd0 : up;
        logic [20:0] s;
        if (pg == 5'd31) return {1'b0, 9'h1FF, a[12:0]};
        if (en && (pg < l || pg >= u)) begin
            s = mdl[pg] + {9'd0, a[12:1]};
            return {1'b1, s, a[0]};
        end
        return {1'b0, 4'd0, a};
    endfunction

    // Called at a falling edge; drives, clocks, checks at the next falling edge
    task automatic step(input logic rv, input logic [17:0] a, input logic en,
                        input logic frc, input logic [4:0] lo, input logic [4:0] up,
                        input logic we, input logic [4:0] wi, input logic [20:0] wd,
                        input string rq);
        logic [22:0] e;
        req_valid = rv; bus_addr = a; map_en = en; force_dflt = frc;
        lo_lim = lo; up_lim = up; wr_en = we; wr_idx = wi; wr_data = wd;
        e = model(a, en, frc, lo, up);
        @(posedge clk);
        if (we) mdl[wi] = wd;
        if (rv) begin
            exp_phys = e[21:0];
            exp_hit = e[22];
            if (e[22]) exp_lma = e[21:0];
        end
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk({rq, " R10 valid"}, 32'(out_valid), 32'(rv));
        chk({rq, " phys"}, 32'(phys_addr), 32'(exp_phys));
        chk({rq, " hit"}, 32'(reloc_hit), 32'(exp_hit));
        chk({rq, " R9 lma"}, 32'(lma), 32'(exp_lma));
    endtask

    task automatic wr(input logic [4:0] wi, input logic [20:0] wd);
        step(1'b0, '0, 1'b0, 1'b0, 5'd0, 5'd31, 1'b1, wi, wd, "R3 write");
        rd_idx = wi;
        #0;
        chk("R3 readback", 32'(rd_data), 32'({wd, 1'b0}));
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        #1;
        chk("R10 reset valid", 32'(out_valid), 0);
        chk("R10 reset phys", 32'(phys_addr), 0);
        chk("R9 reset lma", 32'(lma), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset reg", 32'(rd_data), 0);

        // R3: register writes, bit 0 reads zero
        wr(5'd2, 21'h1ABCDE);
        wr(5'd5, 21'h1FFFFF);
        wr(5'd31, 21'h012345);
        wr(5'd0, 21'h000100);

        // R5: disabled is transparent
        step(1'b1, 18'o123457, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R5 disabled");
        // R4: I/O page ignores enable and register 31
        step(1'b1, 18'o765432, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R4 io enabled");
        step(1'b1, 18'o760001, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R4 io disabled");
        // R1/R2: relocation with odd byte address
        step(1'b1, 18'o047777, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R1 R2 reloc");
        // R1: adder wrap out of the top bit
        step(1'b1, 18'o120006, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R1 wrap");
        // R6/R7: windows lower=3, upper=20
        step(1'b1, 18'o040000, 1'b1, 1'b0, 5'd3, 5'd20, 1'b0, '0, '0, "R6 lower in");
        step(1'b1, 18'o060000, 1'b1, 1'b0, 5'd3, 5'd20, 1'b0, '0, '0, "R7 lower edge");
        step(1'b1, 18'o460000, 1'b1, 1'b0, 5'd3, 5'd20, 1'b0, '0, '0, "R7 below upper");
        step(1'b1, 18'o500002, 1'b1, 1'b0, 5'd3, 5'd20, 1'b0, '0, '0, "R6 upper edge");
        // R6: no windows, then overlap
        step(1'b1, 18'o200000, 1'b1, 1'b0, 5'd0, 5'd31, 1'b0, '0, '0, "R6 no window");
        step(1'b1, 18'o200000, 1'b1, 1'b0, 5'd24, 5'd16, 1'b0, '0, '0, "R6 overlap");
        // R8: force ignores hostile limits
        step(1'b1, 18'o100010, 1'b1, 1'b1, 5'd0, 5'd31, 1'b0, '0, '0, "R8 force");
        // R11: same-edge write uses old base
        step(1'b1, 18'o040010, 1'b1, 1'b0, 5'd0, 5'd0, 1'b1, 5'd2, 21'h000001, "R11 old");
        step(1'b1, 18'o040010, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R11 new");
        // R10: idle cycle holds outputs
        step(1'b0, 18'o777777, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, '0, '0, "R10 hold");

        // Random mix
        begin
            logic [4:0] lo = 5'd0;
            logic [4:0] up = 5'd0;
            logic       en = 1'b1;
            for (int i = 0; i < 3000; i++) begin
                if (i % 150 == 0) begin
                    lo = 5'($urandom);
                    up = 5'($urandom);
                    en = ($urandom % 4) != 0;
                end
                step(($urandom % 5) != 0, 18'($urandom), en, ($urandom % 10) == 0,
                     lo, up, ($urandom % 3) == 0, 5'($urandom), 21'($urandom),
                     "R1 R6 R7 random");
                rd_idx = 5'($urandom);
                #0;
                chk("R3 random read", 32'(rd_data), 32'({mdl[rd_idx], 1'b0}));
            end
        end
        report();
    end
endmodule